// File: doc/BRIEF.md
# Parallel ROM Read Sequencer

This block is the clocked bus-side master for an asynchronous byte-wide read-only memory that has two active-low controls: a select and a read strobe. A host raises a request with an address. The sequencer registers the address onto the memory address bus and asserts the select. It asserts the read strobe later, once the remaining address access time is no longer than the strobe's own access time. It captures the byte when every access path has been satisfied. It then returns the byte with a one-cycle valid pulse and releases both controls in that same cycle.

After the release, the sequencer holds its busy flag high for a float interval. This gives the memory time to stop driving the shared data lines before any other read can begin. All timing figures are parameters in picoseconds. They are converted to whole clock cycles, rounding up, at elaboration, and a cycle count of zero stops elaboration. Decode the select per device and share the read strobe; a device that is not selected stays in standby with its outputs floating.

Top module: `rom_rd_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, mem_ce_n and mem_oe_n are high, rvalid is low and busy is low. A reset in the middle of a read drops that read, and no rvalid follows for it.
- R2: When req is sampled high at a clock edge while busy is low, the next cycle shows mem_ce_n low, mem_addr equal to the sampled addr, and busy high.
- R3: mem_oe_n falls LAG cycles after mem_ce_n falls. RD is the larger of the address and select access counts, OE is the read-strobe count, and LAG is RD minus OE, or 0 when OE is not smaller than RD.
- R4: rvalid is a one-cycle pulse. It rises WAIT cycles after mem_ce_n falls, where WAIT is the larger of RD and OE. In that cycle rdata holds the byte the memory drove at the requested address, and mem_ce_n and mem_oe_n are both back high.
- R5: mem_addr does not change while mem_ce_n stays low.
- R6: busy falls exactly FLT cycles after the rvalid cycle, where FLT is the float count. The next fall of mem_ce_n comes at least FLT+1 cycles after its previous rise.
- R7: A req while busy is high is ignored. It produces no extra rvalid and does not alter mem_addr.
- R8: mem_oe_n is never low while mem_ce_n is high.
- R9: rdata keeps its last captured value until the next rvalid.
- R10: Each cycle count equals the picosecond figure divided by the clock period, rounded up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request from host |
| addr | input | ADDR_W | Read address from host |
| busy | output | 1 | High from acceptance until the float interval ends |
| rvalid | output | 1 | One-cycle strobe marking rdata as new |
| rdata | output | DATA_W | Captured byte |
| mem_addr | output | ADDR_W | Address bus to the memory |
| mem_ce_n | output | 1 | Active-low device select |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_dq | input | DATA_W | Data lines from the memory |

## Verification
The bench uses an 8000 ps clock, a 120000 ps address and select access time, a 50000 ps read-strobe access time and a 40000 ps float time. These give RD 15, OE 7, LAG 8 and FLT 5. With a nonzero LAG, the late strobe and the access window are timed on separate paths, so a strobe that comes early or late shows up. The memory model returns the inverted byte whenever any access path is still short, so a capture one cycle early is visible in rdata. Back-to-back requests bring the float gap to its minimum, and a reset during an access exercises the drop of a read in progress.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FLOAT  = 2'd2
  } rd_state_e;

  function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rom_rd_rstsync.sv
module rom_rd_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/rom_rd_phase_cnt.sv
module rom_rd_phase_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/rom_rd_fsm.sv
module rom_rd_fsm
  import rom_rd_pkg::*;
#(
  parameter int unsigned LAG_CYC  = 8,
  parameter int unsigned WAIT_CYC = 15,
  parameter int unsigned FLT_CYC  = 5,
  parameter int unsigned CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_clr,
  output logic             cnt_en,
  output logic             addr_ld,
  output logic             cap_en,
  output logic             ce_n,
  output logic             oe_n,
  output logic             rvalid,
  output logic             busy
);
  localparam logic [CNT_W-1:0] OE_HIT   = CNT_W'(LAG_CYC - 1);
  localparam logic [CNT_W-1:0] CAP_HIT  = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] FLT_HIT  = CNT_W'(FLT_CYC - 1);
  localparam logic             LATE_OE  = (LAG_CYC != 0);

  rd_state_e state_q, state_d;
  logic      ce_n_q, ce_n_d;
  logic      oe_n_q, oe_n_d;
  logic      rv_q, rv_d;

  always_comb begin
    state_d = state_q;
    ce_n_d  = ce_n_q;
    oe_n_d  = oe_n_q;
    rv_d    = 1'b0;
    cnt_clr = 1'b0;
    cnt_en  = 1'b0;
    addr_ld = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          state_d = ST_ACCESS;
          ce_n_d  = 1'b0;
          oe_n_d  = LATE_OE;
          addr_ld = 1'b1;
          cnt_clr = 1'b1;
        end
      end
      ST_ACCESS: begin
        cnt_en = 1'b1;
        if (LATE_OE && (cnt == OE_HIT)) oe_n_d = 1'b0;
        if (cnt == CAP_HIT) begin
          state_d = ST_FLOAT;
          ce_n_d  = 1'b1;
          oe_n_d  = 1'b1;
          rv_d    = 1'b1;
          cap_en  = 1'b1;
          cnt_clr = 1'b1;
        end
      end
      ST_FLOAT: begin
        cnt_en = 1'b1;
        if (cnt == FLT_HIT) state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        ce_n_d  = 1'b1;
        oe_n_d  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      rv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n_q  <= ce_n_d;
      oe_n_q  <= oe_n_d;
      rv_q    <= rv_d;
    end
  end

  assign ce_n   = ce_n_q;
  assign oe_n   = oe_n_q;
  assign rvalid = rv_q;
  assign busy   = (state_q != ST_IDLE);

  assert_strobe_needs_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_q |-> !ce_n_q);
  assert_rvalid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |=> !rv_q);
  assert_release_on_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |-> (ce_n_q && oe_n_q && busy));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ce_n_q && oe_n_q && !rv_q));
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req) |=> (busy && !ce_n_q));
endmodule

// File: rtl/rom_rd_datapath.sv
module rom_rd_datapath #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_ld,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] data_out
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    if (addr_ld) addr_d = addr_in;
    if (cap_en)  data_d = dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign addr_out = addr_q;
  assign data_out = data_q;

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(data_q));
endmodule

// File: rtl/rom_rd_seq.sv
module rom_rd_seq
  import rom_rd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CLK_PS   = 8000,
  parameter int unsigned T_ACC_PS = 100000,
  parameter int unsigned T_CE_PS  = 100000,
  parameter int unsigned T_OE_PS  = 50000,
  parameter int unsigned T_FLT_PS = 40000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  input  logic [DATA_W-1:0] mem_dq
);
  localparam int unsigned ACC_CYC  = ps_to_cyc(T_ACC_PS, CLK_PS);
  localparam int unsigned CE_CYC   = ps_to_cyc(T_CE_PS, CLK_PS);
  localparam int unsigned OE_CYC   = ps_to_cyc(T_OE_PS, CLK_PS);
  localparam int unsigned FLT_CYC  = ps_to_cyc(T_FLT_PS, CLK_PS);
  localparam int unsigned RD_CYC   = umax(ACC_CYC, CE_CYC);
  localparam int unsigned LAG_CYC  = (RD_CYC > OE_CYC) ? (RD_CYC - OE_CYC) : 0;
  localparam int unsigned WAIT_CYC = umax(RD_CYC, OE_CYC);
  localparam int unsigned CNT_MAX  = umax(WAIT_CYC, FLT_CYC);
  localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);

  if ((ACC_CYC == 0) || (CE_CYC == 0) || (OE_CYC == 0) || (FLT_CYC == 0)) begin : g_bad_timing
    $error("rom_rd_seq: every access and float time must give at least one clock cycle");
  end

  logic             srst_n;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr, cnt_en, addr_ld, cap_en;

  rom_rd_rstsync #(.STAGES(2)) u_rstsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  rom_rd_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .cnt   (cnt)
  );

  rom_rd_fsm #(
    .LAG_CYC  (LAG_CYC),
    .WAIT_CYC (WAIT_CYC),
    .FLT_CYC  (FLT_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (srst_n),
    .req     (req),
    .cnt     (cnt),
    .cnt_clr (cnt_clr),
    .cnt_en  (cnt_en),
    .addr_ld (addr_ld),
    .cap_en  (cap_en),
    .ce_n    (mem_ce_n),
    .oe_n    (mem_oe_n),
    .rvalid  (rvalid),
    .busy    (busy)
  );

  rom_rd_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (srst_n),
    .addr_ld  (addr_ld),
    .cap_en   (cap_en),
    .addr_in  (addr),
    .dq_in    (mem_dq),
    .addr_out (mem_addr),
    .data_out (rdata)
  );

  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  assert_busy_ignores_req_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && !mem_ce_n) |=> $stable(mem_addr) || mem_ce_n);
endmodule

// File: tb/rom_rd_seq_tb.sv
module rom_rd_seq_tb;
  localparam int unsigned AW      = 20;
  localparam int unsigned DW      = 8;
  localparam int unsigned CLK_PS  = 8000;
  localparam int unsigned ACC_PS  = 120000;
  localparam int unsigned OE_PS   = 50000;
  localparam int unsigned FLT_PS  = 40000;

  // R10: cycle counts from ps, rounded up
  function automatic int roundup(input int t, input int p);
    int q;
    q = t / p;
    if (q * p < t) q = q + 1;
    return q;
  endfunction

  localparam int E_RD   = roundup(ACC_PS, CLK_PS);
  localparam int E_OE   = roundup(OE_PS, CLK_PS);
  localparam int E_FLT  = roundup(FLT_PS, CLK_PS);
  localparam int E_LAG  = (E_RD > E_OE) ? E_RD - E_OE : 0;
  localparam int E_WAIT = (E_RD > E_OE) ? E_RD : E_OE;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          busy, rvalid;
  logic [DW-1:0] rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n;
  logic [DW-1:0] mem_dq;

  int checks = 0;
  int errors = 0;

  always #4ns clk = ~clk;

  rom_rd_seq #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLK_PS), .T_ACC_PS(ACC_PS),
    .T_CE_PS(ACC_PS), .T_OE_PS(OE_PS), .T_FLT_PS(FLT_PS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .busy(busy),
    .rvalid(rvalid), .rdata(rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
  );

  // memory model: correct byte only once every access path is satisfied
  function automatic logic [DW-1:0] rom_byte(input logic [AW-1:0] a);
    return (a[7:0] ^ a[15:8] ^ {a[19:16], a[11:8]}) + 8'h3C;
  endfunction

  int            ce_age = 0, oe_age = 0, a_age = 0;
  logic [AW-1:0] a_prev = '0;
  int            ce_dur, oe_dur, a_dur;

  always_comb begin
    ce_dur = mem_ce_n ? 0 : ce_age + 1;
    oe_dur = mem_oe_n ? 0 : oe_age + 1;
    a_dur  = (mem_addr == a_prev) ? a_age + 1 : 1;
    if (ce_dur >= E_RD && oe_dur >= E_OE && a_dur >= E_RD) mem_dq = rom_byte(mem_addr);
    else mem_dq = ~rom_byte(mem_addr);
  end

  always @(posedge clk) begin
    ce_age <= (ce_dur > 1000) ? 1000 : ce_dur;
    oe_age <= (oe_dur > 1000) ? 1000 : oe_dur;
    a_age  <= (a_dur > 1000) ? 1000 : a_dur;
    a_prev <= mem_addr;
  end

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // scoreboard
  logic [AW-1:0] q_addr[$];
  logic [DW-1:0] q_data[$];

  task automatic do_read(input logic [AW-1:0] a);
    @(negedge clk);
    while (busy) @(negedge clk);
    req  = 1'b1;
    addr = a;
    q_addr.push_back(a);
    q_data.push_back(rom_byte(a));
    @(negedge clk);
    req = 1'b0;
  endtask

  // monitor
  int   cyc = 0;
  int   ce_fall = 0, ce_rise = -1000, rv_cyc = 0;
  logic p_ce = 1'b1, p_oe = 1'b1, p_rv = 1'b0, p_busy = 1'b0;
  logic have_last = 1'b0;
  logic [DW-1:0] last_rd = '0;
  bit   mon_on = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      check(!((!mem_oe_n) && mem_ce_n), "R8", mem_oe_n, 1);
      if (p_ce && !mem_ce_n) begin
        ce_fall = cyc;
        check(cyc - ce_rise >= E_FLT + 1, "R6 gap", cyc - ce_rise, E_FLT + 1);
        if (q_addr.size() > 0) check(mem_addr == q_addr[0], "R2 addr", mem_addr, q_addr[0]);
        else check(0, "R7 unexpected access", 1, 0);
        check(busy, "R2 busy", busy, 1);
      end
      if (!p_ce && !mem_ce_n) check(mem_addr == q_addr[0], "R5 R7 addr", mem_addr, q_addr[0]);
      if (!p_ce && mem_ce_n) ce_rise = cyc;
      if (p_oe && !mem_oe_n) check(cyc - ce_fall == E_LAG, "R3", cyc - ce_fall, E_LAG);
      if (rvalid) begin
        rv_cyc = cyc;
        check(!p_rv, "R4 pulse", p_rv, 0);
        check(cyc - ce_fall == E_WAIT, "R4 timing", cyc - ce_fall, E_WAIT);
        check(mem_ce_n && mem_oe_n, "R4 release", {mem_ce_n, mem_oe_n}, 3);
        if (q_data.size() > 0) begin
          check(rdata == q_data[0], "R4 data", rdata, q_data[0]);
          void'(q_data.pop_front());
          void'(q_addr.pop_front());
        end else check(0, "R7 extra rvalid", 1, 0);
        last_rd   = rdata;
        have_last = 1'b1;
      end else if (have_last) begin
        check(rdata == last_rd, "R9", rdata, last_rd);
      end
      if (p_busy && !busy) check(cyc - rv_cyc == E_FLT, "R6 busy", cyc - rv_cyc, E_FLT);
    end
    p_ce = mem_ce_n; p_oe = mem_oe_n; p_rv = rvalid; p_busy = busy;
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n && !rvalid && !busy, "R1 in reset",
          {mem_ce_n, mem_oe_n, rvalid, busy}, 4'b1100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(mem_ce_n && mem_oe_n && !rvalid && !busy, "R1 after release",
          {mem_ce_n, mem_oe_n, rvalid, busy}, 4'b1100);
    mon_on = 1'b1;

    do_read(20'h00000);
    do_read(20'hFFFFF);
    do_read(20'h12345);
    do_read(20'h0AAAA);
    do_read(20'h55555);

    // R7: request while busy is ignored
    do_read(20'h3C3C3);
    repeat (3) @(negedge clk);
    req = 1'b1; addr = 20'h0F0F0;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    check(mem_addr == 20'h3C3C3, "R7 addr kept", mem_addr, 20'h3C3C3);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(q_data.size() == 0 && !busy, "R7 no extra read", q_data.size(), 0);

    // R1: reset in the middle of an access drops the read
    do_read(20'h77777);
    repeat (4) @(negedge clk);
    mon_on = 1'b0;
    rst_n = 1'b0;
    #1ns;
    check(mem_ce_n && mem_oe_n && !rvalid && !busy, "R1 mid-read reset",
          {mem_ce_n, mem_oe_n, rvalid, busy}, 4'b1100);
    q_addr.delete();
    q_data.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    have_last = 1'b0;
    ce_rise = -1000;
    mon_on = 1'b1;
    repeat (30) @(negedge clk);
    check(!busy && mem_ce_n, "R1 read dropped", busy, 0);

    do_read(20'h80001);
    do_read(20'h00100);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(q_data.size() == 0, "R4 all returned", q_data.size(), 0);
    finish_run();
  end
endmodule